// File: doc/BRIEF.md
# SPI Memory Slave Serial Front-End

This block is the serial edge of a memory device that is reached over a four-wire SPI bus. It runs entirely on a fast system clock. It oversamples the bus pins: serial clock, active-low select, data in, an active-low pause input and an active-low write-protect input. Edges of the serial clock are found in the system-clock domain.

Incoming bits are packed most significant bit first into bytes. Each byte goes to a downstream command decoder with a one-cycle strobe. A flag marks the first byte of every frame as the command byte. Outgoing bytes come from the decoder on request and are shifted out most significant bit first. An output-enable tells the pad when to drive the data line.

Clock idle levels low (mode 0) and high (mode 3) both work, with one edge rule for both. A pause input freezes the transfer without deselecting the device. A small guard stops the two block-protect bits from changing while write-protect is asserted.

Top module: `spi_mem_frontend`

## Requirements
- R1: Data in is captured on every rising serial-clock edge of a live frame, most significant bit first. The eighth captured bit completes a byte, which appears on `rx_byte_o` together with a single-cycle `rx_valid_o` pulse.
- R2: The transmit shifter changes only after falling serial-clock edges. `miso_o` carries bit 7 of the current transmit byte first. The first byte of every frame is transmitted as 0x00.
- R3: While select is high, `miso_oe_o` is 0 and the bit counter and transmit shifter return to their start state. Out of reset `miso_oe_o`, `rx_valid_o`, `bp_o` and `wp_reject_o` are all 0.
- R4: After reset nothing is accepted until select has been seen high and then low. A select held low through reset gives no received bytes and no output enable.
- R5: Mode 0 (clock idles low) and mode 3 (clock idles high) frames give identical received bytes and transmitted bits. The leading falling edge of a mode 3 frame shifts nothing.
- R6: While the pause input is low during a selected frame, `miso_oe_o` is 0 and serial clock and data in are ignored. On release, the byte in progress resumes at the same bit in both directions.
- R7: A select rise in the middle of a byte discards the partial byte. The first byte of the next frame is received whole and carries `rx_first_o` = 1. Later bytes of a frame carry `rx_first_o` = 0.
- R8: `tx_req_o` pulses for one cycle at the seventh rising edge of each byte. `tx_byte_i` is taken at the falling edge that follows the eighth rising edge, and becomes the next byte shifted out.
- R9: A status write (`sr_wr_i`) while write-protect is asserted (`wpn_i` low) leaves `bp_o` unchanged and sets `wp_reject_o`. The flag stays set until reset.
- R10: A status write while `wpn_i` is high loads `sr_bp_i` into `bp_o` (2 bits) on the next cycle and does not clear `wp_reject_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the bus master |
| csn_i | input | 1 | Active-low device select |
| mosi_i | input | 1 | Serial data into the device |
| holdn_i | input | 1 | Active-low transfer pause |
| wpn_i | input | 1 | Active-low write-protect for the block-protect bits |
| miso_o | output | 1 | Serial data out of the device |
| miso_oe_o | output | 1 | Pad drive enable for `miso_o` |
| rx_byte_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_byte_o` |
| rx_first_o | output | 1 | Received byte is the first of its frame |
| tx_req_o | output | 1 | One-cycle request for the next transmit byte |
| tx_byte_i | input | DATA_W | Next transmit byte from the decoder |
| sr_wr_i | input | 1 | Status write strobe from the decoder |
| sr_bp_i | input | BP_W | New block-protect value |
| bp_o | output | BP_W | Current block-protect bits |
| wp_reject_o | output | 1 | Sticky flag: a write was blocked by write-protect |

## Verification
A wrong bit counter shows as a received byte that is shifted by one or more positions. It can also show as a missing or extra strobe, and the scoreboard sees this at the end of the affected byte. The same fault also moves `tx_req_o` and the load point of the transmit shifter, so `miso_o` is wrong from the first bit of the next byte. A pause that fails to freeze the state corrupts the byte that spans it, and this is visible a few serial-clock periods after release. A wrong arming or frame state shows up as early as the first byte: bytes accepted before any select fall, a missing command flag, or output enable active while deselected.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

   // Frame tracker states
   typedef enum logic [1:0] {
      FR_UNARMED = 2'd0,   // no genuine select fall seen since reset
      FR_IDLE    = 2'd1,   // armed, deselected
      FR_LIVE    = 2'd2,   // selected, shifting
      FR_PAUSED  = 2'd3    // selected, pause input active
   } frame_state_e;

   // Bit positions inside the synchronizer bundle
   localparam int unsigned PIN_CS   = 0;
   localparam int unsigned PIN_SCK  = 1;
   localparam int unsigned PIN_DIN  = 2;
   localparam int unsigned PIN_HLD  = 3;
   localparam int unsigned PIN_WP   = 4;
   localparam int unsigned PIN_CNT  = 5;

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
   parameter int unsigned         WIDTH   = 5,
   parameter int unsigned         STAGES  = 2,
   parameter logic [WIDTH-1:0]    RST_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_fe_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("spi_fe_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[0] <= RST_VAL;
      else         stage_q[0] <= async_i;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[s] <= RST_VAL;
            else         stage_q[s] <= stage_q[s-1];
         end
      end
   endgenerate

   assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift
   import spi_fe_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cs_n_i,
   input  logic              sck_i,
   input  logic              din_i,
   input  logic              hold_n_i,
   input  logic [DATA_W-1:0] tx_byte_i,
   output logic [DATA_W-1:0] rx_byte_o,
   output logic              rx_valid_o,
   output logic              rx_first_o,
   output logic              tx_req_o,
   output logic              dout_o,
   output logic              dout_oe_o
);

   localparam int unsigned CNT_W   = $clog2(DATA_W);
   localparam int unsigned LAST_AT = DATA_W - 1;
   localparam int unsigned REQ_AT  = DATA_W - 2;

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("spi_fe_shift: DATA_W must be at least 4");
      end
   endgenerate

   frame_state_e      state_q, state_d;
   logic              sck_q, cs_q;
   logic              sck_rise, sck_fall, cs_fall;
   logic [CNT_W-1:0]  bit_cnt_q;
   logic [DATA_W-1:0] rx_sh_q, tx_sh_q;
   logic              first_q, byte_done_q;
   logic              live, framed;

   // Edge detection in the system clock domain
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sck_q <= 1'b0;
         cs_q  <= 1'b0;
      end else begin
         sck_q <= sck_i;
         cs_q  <= cs_n_i;
      end
   end

   assign sck_rise = sck_i & ~sck_q;
   assign sck_fall = ~sck_i & sck_q;
   assign cs_fall  = ~cs_n_i & cs_q;

   // Frame tracker
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         FR_UNARMED: if (cs_fall)   state_d = FR_LIVE;
         FR_IDLE:    if (!cs_n_i)   state_d = FR_LIVE;
         FR_LIVE: begin
            if (cs_n_i)             state_d = FR_IDLE;
            else if (!hold_n_i)     state_d = FR_PAUSED;
         end
         FR_PAUSED: begin
            if (cs_n_i)             state_d = FR_IDLE;
            else if (hold_n_i)      state_d = FR_LIVE;
         end
         default:                   state_d = FR_UNARMED;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= FR_UNARMED;
      else         state_q <= state_d;
   end

   assign live   = (state_q == FR_LIVE);
   assign framed = (state_q == FR_LIVE) || (state_q == FR_PAUSED);

   // Receive path, bit counter and frame bookkeeping
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bit_cnt_q   <= '0;
         rx_sh_q     <= '0;
         rx_byte_o   <= '0;
         rx_valid_o  <= 1'b0;
         rx_first_o  <= 1'b0;
         tx_req_o    <= 1'b0;
         first_q     <= 1'b1;
         byte_done_q <= 1'b0;
         tx_sh_q     <= '0;
      end else begin
         rx_valid_o <= 1'b0;
         tx_req_o   <= 1'b0;
         if (!framed) begin
            bit_cnt_q   <= '0;
            first_q     <= 1'b1;
            byte_done_q <= 1'b0;
            tx_sh_q     <= '0;
         end else if (live) begin
            if (sck_rise) begin
               rx_sh_q <= {rx_sh_q[DATA_W-2:0], din_i};
               if (bit_cnt_q == CNT_W'(REQ_AT)) tx_req_o <= 1'b1;
               if (bit_cnt_q == CNT_W'(LAST_AT)) begin
                  bit_cnt_q   <= '0;
                  rx_byte_o   <= {rx_sh_q[DATA_W-2:0], din_i};
                  rx_valid_o  <= 1'b1;
                  rx_first_o  <= first_q;
                  first_q     <= 1'b0;
                  byte_done_q <= 1'b1;
               end else begin
                  bit_cnt_q <= bit_cnt_q + 1'b1;
               end
            end
            if (sck_fall) begin
               if (byte_done_q) begin
                  tx_sh_q     <= tx_byte_i;
                  byte_done_q <= 1'b0;
               end else if (bit_cnt_q != '0) begin
                  tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign dout_o    = tx_sh_q[DATA_W-1];
   assign dout_oe_o = live;

   // R1: the byte strobe lasts one cycle
   assert_rx_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_valid_o |=> !rx_valid_o);

   // R8: the transmit request lasts one cycle
   assert_tx_req_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_req_o |=> !tx_req_o);

   // R4: nothing is received before arming
   assert_no_rx_unarmed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == FR_UNARMED) |=> !rx_valid_o);

   // R6: a pause freezes counter and both shifters
   assert_hold_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == FR_PAUSED) |=> ($stable(bit_cnt_q) && $stable(tx_sh_q) && $stable(rx_sh_q)));

   // R3: deselect returns the counter to the start of a byte
   assert_cs_high_reset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (framed && cs_n_i) |=> ##1 (bit_cnt_q == '0));

   // R3: no drive while deselected
   assert_no_drive_desel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cs_n_i && cs_q) |-> !dout_oe_o);

endmodule

// File: rtl/spi_fe_prot.sv
module spi_fe_prot #(
   parameter int unsigned BP_W = 2
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            wp_n_i,
   input  logic            wr_i,
   input  logic [BP_W-1:0] bp_i,
   output logic [BP_W-1:0] bp_o,
   output logic            reject_o
);

   generate
      if (BP_W < 1) begin : g_bad_bp
         $error("spi_fe_prot: BP_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bp_o     <= '0;
         reject_o <= 1'b0;
      end else if (wr_i) begin
         if (wp_n_i) bp_o     <= bp_i;
         else        reject_o <= 1'b1;
      end
   end

   // R9: protected writes leave the bits alone and raise the flag
   assert_wp_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !wp_n_i) |=> ($stable(bp_o) && reject_o));

   // R9: the reject flag is sticky
   assert_reject_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reject_o |=> reject_o);

   // R10: unprotected writes load the new value
   assert_wp_open_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && wp_n_i) |=> (bp_o == $past(bp_i)));

endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend
   import spi_fe_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned BP_W        = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sclk_i,
   input  logic              csn_i,
   input  logic              mosi_i,
   input  logic              holdn_i,
   input  logic              wpn_i,
   output logic              miso_o,
   output logic              miso_oe_o,
   output logic [DATA_W-1:0] rx_byte_o,
   output logic              rx_valid_o,
   output logic              rx_first_o,
   output logic              tx_req_o,
   input  logic [DATA_W-1:0] tx_byte_i,
   input  logic              sr_wr_i,
   input  logic [BP_W-1:0]   sr_bp_i,
   output logic [BP_W-1:0]   bp_o,
   output logic              wp_reject_o
);

   // Select resets to "low" so a select held low through reset never arms.
   localparam logic [PIN_CNT-1:0] SYNC_RST =
      PIN_CNT'((1 << PIN_HLD) | (1 << PIN_WP));

   logic [PIN_CNT-1:0] pins_raw, pins_s;

   always_comb begin
      pins_raw          = '0;
      pins_raw[PIN_CS]  = csn_i;
      pins_raw[PIN_SCK] = sclk_i;
      pins_raw[PIN_DIN] = mosi_i;
      pins_raw[PIN_HLD] = holdn_i;
      pins_raw[PIN_WP]  = wpn_i;
   end

   spi_fe_sync #(
      .WIDTH   (PIN_CNT),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (pins_raw),
      .sync_o  (pins_s)
   );

   spi_fe_shift #(
      .DATA_W (DATA_W)
   ) u_shift (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cs_n_i     (pins_s[PIN_CS]),
      .sck_i      (pins_s[PIN_SCK]),
      .din_i      (pins_s[PIN_DIN]),
      .hold_n_i   (pins_s[PIN_HLD]),
      .tx_byte_i  (tx_byte_i),
      .rx_byte_o  (rx_byte_o),
      .rx_valid_o (rx_valid_o),
      .rx_first_o (rx_first_o),
      .tx_req_o   (tx_req_o),
      .dout_o     (miso_o),
      .dout_oe_o  (miso_oe_o)
   );

   spi_fe_prot #(
      .BP_W (BP_W)
   ) u_prot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wp_n_i   (pins_s[PIN_WP]),
      .wr_i     (sr_wr_i),
      .bp_i     (sr_bp_i),
      .bp_o     (bp_o),
      .reject_o (wp_reject_o)
   );

endmodule

// File: tb/spi_mem_frontend_tb.sv
module spi_mem_frontend_tb;

   localparam int H = 8;   // system cycles per serial half period

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0, csn = 1'b0, mosi = 1'b0, holdn = 1'b1, wpn = 1'b1;
   logic       miso, miso_oe, rx_valid, rx_first, tx_req, sr_wr = 1'b0, wp_reject;
   logic [7:0] rx_byte, tx_byte = 8'h00;
   logic [1:0] sr_bp = 2'b00, bp;

   int n_cmp = 0, n_bad = 0;
   logic [8:0] exp_q[$];
   logic [7:0] txd_q[$];
   bit   first_flag;

   always #10 clk = ~clk;   // 50 MHz

   spi_mem_frontend u_dut (
      .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
      .holdn_i(holdn), .wpn_i(wpn), .miso_o(miso), .miso_oe_o(miso_oe),
      .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .rx_first_o(rx_first),
      .tx_req_o(tx_req), .tx_byte_i(tx_byte), .sr_wr_i(sr_wr), .sr_bp_i(sr_bp),
      .bp_o(bp), .wp_reject_o(wp_reject)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Monitor: received bytes against the scoreboard, transmit requests served
   always @(negedge clk) begin
      if (rx_valid) begin
         if (exp_q.size() == 0) chk(1'b0, "R4 unexpected byte", {rx_first, rx_byte}, 0);
         else begin
            logic [8:0] e;
            e = exp_q.pop_front();
            chk({rx_first, rx_byte} == e, "R1/R7 rx byte+first", {rx_first, rx_byte}, e);
         end
      end
      if (tx_req) tx_byte <= (txd_q.size() != 0) ? txd_q.pop_front() : 8'h00;
   end

   task automatic wait_c(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bits(input logic [7:0] b, input logic [7:0] ex, input bit do_chk,
                            input int hi, input int lo, input string req);
      for (int i = hi; i >= lo; i--) begin
         sclk = 1'b0;
         mosi = b[i];
         wait_c(H);
         if (do_chk) begin
            chk(miso_oe == 1'b1, "R3 oe while selected", miso_oe, 1);
            chk(miso == ex[i], req, miso, ex[i]);
         end
         sclk = 1'b1;
         wait_c(H);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input logic [7:0] ex, input string req);
      exp_q.push_back({first_flag, b});
      first_flag = 1'b0;
      send_bits(b, ex, 1'b1, 7, 0, req);
   endtask

   task automatic begin_frame(input bit mode3);
      txd_q.delete();
      sclk = mode3;
      wait_c(H);
      csn = 1'b0;
      wait_c(H);
      first_flag = 1'b1;
   endtask

   task automatic end_frame();
      sclk = 1'b0;   // mode 0 idle; a mode 3 bench re-raises below
      wait_c(H);
      csn = 1'b1;
      wait_c(2 * H);
      chk(miso_oe == 1'b0, "R3 oe after deselect", miso_oe, 0);
   endtask

   task automatic sr_write(input logic [1:0] v);
      sr_bp = v;
      sr_wr = 1'b1;
      wait_c(1);
      sr_wr = 1'b0;
      wait_c(2);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      // Reset with select held low the whole time
      wait_c(5);
      chk(miso_oe == 1'b0, "R3 reset oe", miso_oe, 0);
      chk(rx_valid == 1'b0, "R3 reset rx_valid", rx_valid, 0);
      rst_n = 1'b1;
      wait_c(4);
      chk(bp == 2'b00, "R3 reset bp", bp, 0);
      chk(wp_reject == 1'b0, "R3 reset reject", wp_reject, 0);
      // R4: traffic before any select fall is ignored
      send_bits(8'hA7, 8'h00, 1'b0, 7, 0, "R4");
      sclk = 1'b0;
      wait_c(H);
      chk(miso_oe == 1'b0, "R4 no drive before arming", miso_oe, 0);
      chk(exp_q.size() == 0, "R4 scoreboard idle", exp_q.size(), 0);
      csn = 1'b1;
      wait_c(4 * H);

      // R5 mode 0 frame: R1 capture, R2 first byte zero, R8 transmit load
      begin_frame(1'b0);
      txd_q.push_back(8'hA5);
      txd_q.push_back(8'h3C);
      send_byte(8'h9F, 8'h00, "R2 first byte zero (mode 0)");
      send_byte(8'h12, 8'hA5, "R8 tx byte 1 (mode 0)");
      send_byte(8'h34, 8'h3C, "R8 tx byte 2 (mode 0)");
      end_frame();

      // R5 mode 3 frame
      begin_frame(1'b1);
      txd_q.push_back(8'h81);
      txd_q.push_back(8'h7E);
      send_byte(8'h06, 8'h00, "R5 first byte zero (mode 3)");
      send_byte(8'hC3, 8'h81, "R5 tx byte 1 (mode 3)");
      send_byte(8'h5A, 8'h7E, "R5 tx byte 2 (mode 3)");
      sclk = 1'b1;
      wait_c(H);
      csn = 1'b1;
      wait_c(2 * H);
      chk(miso_oe == 1'b0, "R3 oe after mode 3 frame", miso_oe, 0);

      // R6 pause mid-byte
      begin_frame(1'b0);
      txd_q.push_back(8'hF0);
      send_byte(8'h05, 8'h00, "R6 lead byte");
      exp_q.push_back({1'b0, 8'hB6});
      send_bits(8'hB6, 8'hF0, 1'b1, 7, 4, "R6 before pause");
      sclk = 1'b0;
      wait_c(H);
      holdn = 1'b0;
      wait_c(H);
      chk(miso_oe == 1'b0, "R6 no drive in pause", miso_oe, 0);
      for (int k = 0; k < 3; k++) begin
         mosi = ~mosi;
         sclk = 1'b1;
         wait_c(H);
         sclk = 1'b0;
         wait_c(H);
      end
      chk(miso_oe == 1'b0, "R6 still paused", miso_oe, 0);
      holdn = 1'b1;
      wait_c(H);
      send_bits(8'hB6, 8'hF0, 1'b1, 3, 0, "R6 resumed tx bits");
      end_frame();

      // R7 select rise mid-byte, then a fresh frame
      begin_frame(1'b0);
      send_bits(8'hFF, 8'h00, 1'b0, 7, 5, "R7");
      end_frame();
      begin_frame(1'b0);
      send_byte(8'h4D, 8'h00, "R7 fresh frame zero tx");
      end_frame();
      wait_c(H);
      chk(exp_q.size() == 0, "R1 all bytes delivered", exp_q.size(), 0);

      // R9 / R10 write-protect
      wpn = 1'b0;
      wait_c(5);
      sr_write(2'b11);
      chk(bp == 2'b00, "R9 bp unchanged", bp, 0);
      chk(wp_reject == 1'b1, "R9 reject set", wp_reject, 1);
      wpn = 1'b1;
      wait_c(5);
      sr_write(2'b10);
      chk(bp == 2'b10, "R10 bp written", bp, 2);
      chk(wp_reject == 1'b1, "R10 reject kept", wp_reject, 1);
      wpn = 1'b0;
      wait_c(5);
      sr_write(2'b01);
      chk(bp == 2'b10, "R9 bp held again", bp, 2);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule